// File: doc/BRIEF.md
# Masked Terminal-Count Clock Divider

This block divides its clock with a free-running binary counter. The counter restarts when its value equals a fixed terminal pattern. The comparison looks only at the bit positions selected by a care mask, so positions outside the mask never take part in the decision. Because of this, the division period is set by the smallest count that agrees with the target on the cared bits, not by the full target value.

On every cycle where the masked comparison holds, a one-cycle match pulse is raised. On the next rising edge the counter returns to zero and a registered divided output inverts. The target and mask are elaboration-time parameters as wide as the counter.

The defaults are a 25-bit counter, an all-ones target and bit 6 left out of the mask. With these values the counter restarts after 2^25 − 64 counts. The wildcard is built from ordinary gates, so it behaves the same in hardware and in simulation.

Top module: `mask_tc_divider`

## Requirements
- R1: While synchronous reset is high, and on the cycle after it is released, the counter is zero, the divided output is 0 and the match pulse is 0.
- R2: With no match, the counter advances by one on every rising edge. The first match pulse is seen exactly M cycles after reset release, where M is the smallest count equal to the target on every masked bit.
- R3: A mask bit of 1 means that position must equal the target bit. A mask bit of 0 means that position is ignored, whatever its value in the counter or in the target.
- R4: When M is nonzero, the match pulse lasts exactly one cycle.
- R5: On the edge after a match, the counter clears to zero instead of incrementing, so later match pulses come every M+1 cycles.
- R6: The divided output inverts on the edge after each match pulse and holds its value on every other edge.
- R7: An all-ones mask gives a plain full-width terminal count: pulses come every 2^W cycles when the target is all ones.
- R8: Asserting reset in the middle of a run restarts the sequence from count zero, with the divided output at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| divOut | output | 1 | Divided output; inverts once per counter restart |
| matchPulse | output | 1 | High while the counter satisfies the masked terminal compare |

## Verification
The design is instantiated three ways: an 8-bit all-ones target with bit 6 ignored (M = 191), a 6-bit all-ones target with a full mask (M = 63), and an 8-bit target 0x35 with only the high nibble cared (M = 48). The first instance separates a masked compare from a plain all-ones compare, because the two give different periods. The second shows that a full mask falls back to a plain terminal count. The third has nonzero target bits outside the mask, which catches any design that lets ignored target bits leak into the compare. A reset issued mid-run, while one divided output is high, shows that the sequence restarts.

// File: rtl/mask_tc_pkg.sv
package mask_tc_pkg;
  // Strobes from the control side to the datapath.
  typedef struct packed {
    logic clearCnt;   // load zero instead of incrementing
    logic toggleOut;  // invert the divided output
  } divStrobes_t;
endpackage

// File: rtl/mask_tc_datapath.sv
module mask_tc_datapath
  import mask_tc_pkg::*;
#(
  parameter int WIDTH = 25
) (
  input  logic             clk,
  input  logic             rst,
  input  divStrobes_t      stb,
  output logic [WIDTH-1:0] cnt,
  output logic             divOut
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (stb.clearCnt) cnt <= '0;
    else                   cnt <= cnt + ONE;
  end

  always_ff @(posedge clk) begin
    if (rst)                divOut <= 1'b0;
    else if (stb.toggleOut) divOut <= ~divOut;
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> (cnt == '0 && !divOut));

  assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
    !stb.clearCnt |=> cnt == $past(cnt) + ONE);

  assert_clear_on_match_R5: assert property (@(posedge clk) disable iff (rst)
    stb.clearCnt |=> cnt == '0);

  assert_toggle_R6: assert property (@(posedge clk) disable iff (rst)
    stb.toggleOut |=> divOut != $past(divOut));

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !stb.toggleOut |=> $stable(divOut));
endmodule

// File: rtl/mask_tc_control.sv
module mask_tc_control
  import mask_tc_pkg::*;
#(
  parameter int               WIDTH  = 25,
  parameter logic [WIDTH-1:0] TARGET = '1,
  parameter logic [WIDTH-1:0] MASK   = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] cnt,
  output divStrobes_t      stb,
  output logic             matchPulse
);
  // A zero terminal value would give a pulse on every cycle.
  localparam bit NONZERO_TERM = ((TARGET & MASK) != '0);

  logic [WIDTH-1:0] bitOk;

  // Each position passes if it is ignored or equals the target bit.
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (MASK[i]) begin : g_care
      assign bitOk[i] = (cnt[i] == TARGET[i]);
    end else begin : g_ignore
      assign bitOk[i] = 1'b1;
    end
  end

  assign matchPulse    = &bitOk;
  assign stb.clearCnt  = matchPulse;
  assign stb.toggleOut = matchPulse;

  if (NONZERO_TERM) begin : g_width_chk
    assert_pulse_width_R4: assert property (@(posedge clk) disable iff (rst)
      matchPulse |=> !matchPulse);
  end
endmodule

// File: rtl/mask_tc_divider.sv
module mask_tc_divider #(
  parameter int                 WIDTH  = 25,
  parameter logic [WIDTH-1:0]   TARGET = '1,
  parameter logic [WIDTH-1:0]   MASK   = ~(WIDTH'(1) << 6)
) (
  input  logic clk,
  input  logic rst,
  output logic divOut,
  output logic matchPulse
);
  import mask_tc_pkg::*;

  divStrobes_t      stb;
  logic [WIDTH-1:0] cnt;

  mask_tc_control #(.WIDTH(WIDTH), .TARGET(TARGET), .MASK(MASK)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .cnt        (cnt),
    .stb        (stb),
    .matchPulse (matchPulse)
  );

  mask_tc_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .stb    (stb),
    .cnt    (cnt),
    .divOut (divOut)
  );
endmodule

// File: tb/mask_tc_divider_test.sv
`timescale 1ns/1ps
module mask_tc_divider_test;
  typedef struct {
    int   idx;
    logic lvl;
  } expItem_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic divA, pulseA, divB, pulseB, divC, pulseC;

  // A: bit 6 ignored; B: full mask (R7); C: low nibble ignored, target 0x35
  mask_tc_divider #(.WIDTH(8), .TARGET(8'hFF), .MASK(8'hBF)) uut (
    .clk(clk), .rst(rst), .divOut(divA), .matchPulse(pulseA));
  mask_tc_divider #(.WIDTH(6), .TARGET(6'h3F), .MASK(6'h3F)) uutFull (
    .clk(clk), .rst(rst), .divOut(divB), .matchPulse(pulseB));
  mask_tc_divider #(.WIDTH(8), .TARGET(8'h35), .MASK(8'hF0)) uutLow (
    .clk(clk), .rst(rst), .divOut(divC), .matchPulse(pulseC));

  expItem_t qA[$], qB[$], qC[$];
  int checks = 0, errors = 0, sample = 0;
  int mA, mB, mC;
  bit running = 1'b0, done = 1'b0;

  // Smallest count that agrees with the target on every cared bit
  function automatic int firstHit(int w, int tgt, int msk);
    for (int v = 0; v < (1 << w); v++)
      if (((v ^ tgt) & msk) == 0) return v;
    return -1;
  endfunction

  // Driver: queue expected pulse positions and output levels
  task automatic pushUnit(ref expItem_t q[$], input int m, input int runLen);
    for (int k = 0; m + k * (m + 1) < runLen; k++) begin
      expItem_t it;
      it.idx = m + k * (m + 1);
      it.lvl = logic'(k % 2);
      q.push_back(it);
    end
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Monitor for one instance at one sample point
  task automatic checkUnit(ref expItem_t q[$], input string name, input int m,
                           input logic pulse, input logic lvl, input int s);
    int expLvl;
    expLvl = (s <= m) ? 0 : ((((s - m - 1) / (m + 1)) + 1) % 2);
    check(lvl === logic'(expLvl), "R6", {name, " divOut"}, int'(lvl), expLvl);
    if (pulse === 1'b1) begin
      if (q.size() == 0) begin
        check(1'b0, "R4", {name, " extra pulse at sample"}, s, -1);
      end else begin
        expItem_t it;
        it = q.pop_front();
        // first pulse checks the masked compare (R2, R3); later ones the restart (R5)
        check(it.idx == s, (it.idx == m) ? "R3" : "R5",
              {name, " pulse sample"}, s, it.idx);
        check(lvl === it.lvl, "R6", {name, " level at pulse"}, int'(lvl), int'(it.lvl));
      end
    end else if (q.size() > 0 && q[0].idx == s) begin
      check(1'b0, "R2", {name, " missing pulse at sample"}, s, q[0].idx);
      void'(q.pop_front());
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      checkUnit(qA, "A", mA, pulseA, divA, sample);
      checkUnit(qB, "B", mB, pulseB, divB, sample);
      checkUnit(qC, "C", mC, pulseC, divC, sample);
      sample++;
    end
  end

  task automatic resetChecks(input string req);
    check(divA === 1'b0 && divB === 1'b0 && divC === 1'b0, req, "divOut after reset",
          int'({divA, divB, divC}), 0);
    check(pulseA === 1'b0 && pulseB === 1'b0 && pulseC === 1'b0, req, "pulse after reset",
          int'({pulseA, pulseB, pulseC}), 0);
  endtask

  task automatic runPhase(input int runLen, input string req);
    qA.delete(); qB.delete(); qC.delete();
    pushUnit(qA, mA, runLen);
    pushUnit(qB, mB, runLen);
    pushUnit(qC, mC, runLen);
    @(posedge clk);
    #1 rst = 1'b0;
    sample = 0;
    running = 1'b1;
    wait (sample >= runLen);
    running = 1'b0;
    check(qA.size() == 0, req, "A pulses left unseen", qA.size(), 0);
    check(qB.size() == 0, "R7", "B pulses left unseen", qB.size(), 0);
    check(qC.size() == 0, "R3", "C pulses left unseen", qC.size(), 0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    mA = firstHit(8, 'hFF, 'hBF);   // 191
    mB = firstHit(6, 'h3F, 'h3F);   // 63
    mC = firstHit(8, 'h35, 'hF0);   // 48
    check(mA == 191 && mB == 63 && mC == 48, "R3", "model terminal values",
          mA, 191);
    repeat (4) @(posedge clk);
    @(negedge clk);
    resetChecks("R1");
    runPhase(600, "R2");
    check(divA === 1'b1, "R6", "A level before mid-run reset", int'(divA), 1);
    @(posedge clk);
    #1 rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    resetChecks("R8");
    runPhase(300, "R8");
    finishRun();
  end

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", sample, 0);
    finishRun();
  end
endmodule